// File: doc/BRIEF.md
# Time-Base Bit-Select Interval Timer

This block turns a shared, free-running 64-bit time base into a periodic event. A configuration picks one bit of the time base. Each time that bit goes from 0 to 1, the block emits a single-cycle event pulse. The status logic elsewhere uses that pulse to set its own pending flag. The same block is placed twice: once as the fixed-interval timer, whose pulse sets the fixed-interval status bit, and once as the watchdog tick, whose pulse sets the watchdog status bit.

The bit position comes from a 2-bit period field, in one of two ways. In table mode the field selects one of four bit positions set by a parameter. In extended mode a 4-bit extension is placed above the period field to form a 6-bit value, and the position is 63 minus that value. The index is reloaded on the clock edge of a configuration write. While the status flag fed back from the register unit is pending, the block suppresses its pulses. A rising edge that happens during that time is dropped, not kept for later.

Top module: `tbsel_timer`

## Requirements
- R1: `evt_o` is high for exactly one cycle. It goes high in the cycle after a clock edge at which the selected bit reads 1, provided that bit read 0 at the previous edge and no other rule blocks the event.
- R2: When `cfg_wr_i`=1 and `cfg_ext_i`=1, `idx_o` takes the value 63 − ({`cfg_xt_i`,`cfg_per_i`} read as a 6-bit number, extension in bits 5:2) from the next cycle on.
- R3: When `cfg_wr_i`=1 and `cfg_ext_i`=0, `idx_o` takes the table entry for `cfg_per_i` from the next cycle on. With default parameters the entries are 0→21, 1→25, 2→29, 3→33.
- R4: After reset, `idx_o` is 21 (table entry 0) and `evt_o` is 0. The first two edges after reset is released produce no event.
- R5: If `pend_i` is 1 at the edge where a rising edge is seen, no event is produced, and that rising edge is lost.
- R6: `idx_o` changes only after an edge at which `cfg_wr_i` is 1.
- R7: At the first edge after the index is reloaded, no event is produced, even if the newly selected bit reads 1 and the old one read 0.
- R8: A selected bit that falls or stays the same produces no event.
- R9: With a time base that counts up by one per cycle, events at index k are 2^(k+1) cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| tbase_i | input | 64 | Free-running time base |
| cfg_wr_i | input | 1 | Configuration write strobe; the index is reloaded at this edge |
| cfg_ext_i | input | 1 | 1 selects extended mode, 0 selects table mode |
| cfg_per_i | input | 2 | Period field |
| cfg_xt_i | input | 4 | Period extension, used only in extended mode |
| pend_i | input | 1 | Status flag for this timer is still pending |
| evt_o | output | 1 | One-cycle event pulse |
| idx_o | output | 6 | Time-base bit currently selected |

## Verification
An index register holding a wrong value shows on `idx_o` one cycle after the write. It also moves the events in time, so the pulse train no longer lines up with transitions of the intended time-base bit. A history bit that is wrong, or a missed reload suppression, shows as an extra or missing pulse at the first edge after a configuration write or after reset. A pending filter that is broken shows as a pulse while `pend_i` is high. The bench compares `evt_o` and `idx_o` with a behavioural model at every cycle, so each of these faults is reported in the cycle it first shows.

// File: rtl/tbsel_pkg.sv
package tbsel_pkg;
  localparam int TB_W   = 64;
  localparam int IDX_W  = $clog2(TB_W);
  localparam int PER_W  = 2;
  localparam int XT_W   = IDX_W - PER_W;
  localparam int N_TAB  = 1 << PER_W;

  // default table: entries 21, 25, 29, 33 (entry 0 in the low bits)
  localparam logic [N_TAB*IDX_W-1:0] DEF_TAB = {6'd33, 6'd29, 6'd25, 6'd21};

  // extended mode: index counts down from the top bit
  function automatic logic [IDX_W-1:0] ext_index(input logic [XT_W-1:0] xt,
                                                 input logic [PER_W-1:0] per);
    logic [IDX_W-1:0] fld;
    fld = {xt, per};
    return IDX_W'(TB_W - 1) - fld;
  endfunction
endpackage

// File: rtl/tbsel_index.sv
module tbsel_index
  import tbsel_pkg::*;
#(
  parameter logic [N_TAB*IDX_W-1:0] PER_TAB = DEF_TAB
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic             ext_i,
  input  logic [PER_W-1:0] per_i,
  input  logic [XT_W-1:0]  xt_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             chg_o
);
  logic [IDX_W-1:0] tab [N_TAB];
  logic [IDX_W-1:0] idx_d, idx_q;
  logic             chg_d, chg_q;

  for (genvar g = 0; g < N_TAB; g++) begin : g_tab
    assign tab[g] = PER_TAB[g*IDX_W +: IDX_W];
  end

  always_comb begin
    idx_d = idx_q;
    chg_d = wr_i;
    if (wr_i) begin
      if (ext_i) idx_d = ext_index(xt_i, per_i);
      else       idx_d = tab[per_i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= PER_TAB[IDX_W-1:0];
      chg_q <= 1'b1;
    end else begin
      idx_q <= idx_d;
      chg_q <= chg_d;
    end
  end

  assign idx_o = idx_q;
  assign chg_o = chg_q;

  p_idx_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> $stable(idx_q));
  p_ext_idx_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && ext_i) |=> idx_q == IDX_W'(TB_W - 1) - IDX_W'({$past(xt_i), $past(per_i)}));
  p_tab_idx_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && !ext_i) |=> idx_q == tab[$past(per_i)]);
endmodule

// File: rtl/tbsel_edge.sv
module tbsel_edge
  import tbsel_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TB_W-1:0]  tbase_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             chg_i,
  input  logic             pend_i,
  output logic             evt_o
);
  logic bit_now;
  logic hist_d, hist_q;
  logic evt_d, evt_q;

  assign bit_now = tbase_i[idx_i];

  always_comb begin
    hist_d = bit_now;
    // a reload or a pending flag swallows the edge
    evt_d  = bit_now & ~hist_q & ~chg_i & ~pend_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= 1'b0;
      evt_q  <= 1'b0;
    end else begin
      hist_q <= hist_d;
      evt_q  <= evt_d;
    end
  end

  assign evt_o = evt_q;

  p_pend_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    evt_q |-> !$past(pend_i));
  p_single_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    evt_q |=> !evt_q);
  p_reload_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    chg_i |=> !evt_q);
endmodule

// File: rtl/tbsel_timer.sv
module tbsel_timer
  import tbsel_pkg::*;
#(
  parameter logic [N_TAB*IDX_W-1:0] PER_TAB = DEF_TAB
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TB_W-1:0]  tbase_i,
  input  logic             cfg_wr_i,
  input  logic             cfg_ext_i,
  input  logic [PER_W-1:0] cfg_per_i,
  input  logic [XT_W-1:0]  cfg_xt_i,
  input  logic             pend_i,
  output logic             evt_o,
  output logic [IDX_W-1:0] idx_o
);
  logic rs0_q, rs1_q;
  logic rst_core_n;
  logic chg;
  logic [IDX_W-1:0] idx;

  // reset asserts at once, releases after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs0_q <= 1'b0;
      rs1_q <= 1'b0;
    end else begin
      rs0_q <= 1'b1;
      rs1_q <= rs0_q;
    end
  end
  assign rst_core_n = rs1_q;

  tbsel_index #(.PER_TAB(PER_TAB)) u_index (
    .clk   (clk),
    .rst_n (rst_core_n),
    .wr_i  (cfg_wr_i),
    .ext_i (cfg_ext_i),
    .per_i (cfg_per_i),
    .xt_i  (cfg_xt_i),
    .idx_o (idx),
    .chg_o (chg)
  );

  tbsel_edge u_edge (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .tbase_i (tbase_i),
    .idx_i   (idx),
    .chg_i   (chg),
    .pend_i  (pend_i),
    .evt_o   (evt_o)
  );

  assign idx_o = idx;

  p_cfg_quiet_r7: assert property (@(posedge clk) disable iff (!rst_core_n)
    cfg_wr_i |=> ##1 !evt_o);
endmodule

// File: tb/tb_tbsel_timer.sv
module tb_tbsel_timer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [63:0] tb;
  logic        wr, ext, pend;
  logic [1:0]  per;
  logic [3:0]  xt;
  logic        evt_o;
  logic [5:0]  idx_o;

  always #10 clk = ~clk;

  tbsel_timer dut (
    .clk(clk), .rst_n(rst_n), .tbase_i(tb), .cfg_wr_i(wr), .cfg_ext_i(ext),
    .cfg_per_i(per), .cfg_xt_i(xt), .pend_i(pend), .evt_o(evt_o), .idx_o(idx_o)
  );

  int    vecs = 0, errs = 0, evcnt = 0;
  string tag  = "R4";
  int    m_idx;
  bit    m_hist, m_chg, m_evt, m_s0, m_s1;

  function automatic int exp_index(bit e, int p, int x);
    if (e) return 63 - (x * 4 + p);
    return 21 + 4 * p;
  endfunction

  task automatic model_edge();
    if (!rst_n) begin
      m_s0 = 0; m_s1 = 0;
      m_idx = 21; m_chg = 1; m_hist = 0; m_evt = 0;
    end else begin
      if (!m_s1) begin
        m_idx = 21; m_chg = 1; m_hist = 0; m_evt = 0;
      end else begin
        bit b;
        b = tb[m_idx];
        m_evt  = b && !m_hist && !m_chg && !pend;
        m_hist = b;
        m_chg  = wr;
        if (wr) m_idx = exp_index(ext, per, xt);
      end
      m_s1 = m_s0; m_s0 = 1;
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    vecs++;
    if (evt_o) evcnt++;
    if (evt_o !== m_evt || idx_o !== 6'(m_idx)) begin
      errs++;
      $display("FAIL %s: evt=%b idx=%0d, expected evt=%b idx=%0d",
               tag, evt_o, idx_o, m_evt, m_idx);
    end
  endtask

  task automatic chk(string t, int act, int exp);
    vecs++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: got %0d, expected %0d", t, act, exp);
    end
  endtask

  task automatic write_cfg(bit e, int p, int x);
    wr = 1; ext = e; per = 2'(p); xt = 4'(x);
    cyc();
    wr = 0;
  endtask

  initial begin
    #(20 * 200000);
    errs++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    rst_n = 0; tb = 0; wr = 0; ext = 0; pend = 0; per = 0; xt = 0;
    model_edge();
    repeat (3) cyc();
    rst_n = 1;
    tb = 64'hFFFF_FFFF_FFFF_FFFF;  // all bits high right at release
    repeat (3) cyc();
    // R4: reset index and no event after release
    chk("R4 idx", int'(idx_o), 21);
    chk("R4 evt", int'(evt_o), 0);

    // R3: table mode entries
    tag = "R3";
    for (int p = 0; p < 4; p++) begin
      write_cfg(0, p, 9);
      chk("R3 table idx", int'(idx_o), 21 + 4 * p);
    end

    // R2: extended mode
    tag = "R2";
    write_cfg(1, 0, 0);  chk("R2 ext 0", int'(idx_o), 63);
    write_cfg(1, 3, 15); chk("R2 ext 63", int'(idx_o), 0);
    write_cfg(1, 2, 5);  chk("R2 ext 22", int'(idx_o), 41);
    // R6: no write, index held
    tag = "R6";
    per = 1; xt = 7;
    repeat (3) cyc();
    chk("R6 hold", int'(idx_o), 41);

    // R9, R1: counting time base at index 2
    tag = "R9";
    tb = 0;
    write_cfg(1, 1, 15);
    chk("R2 idx 2", int'(idx_o), 2);
    evcnt = 0;
    for (int i = 1; i <= 64; i++) begin tb = 64'(i); cyc(); end
    repeat (2) cyc();
    chk("R9 events in 64 ticks", evcnt, 8);

    // R5: pending blocks all events
    tag = "R5";
    pend = 1; evcnt = 0;
    for (int i = 65; i <= 128; i++) begin tb = 64'(i); cyc(); end
    chk("R5 none while pending", evcnt, 0);
    pend = 0;

    // R7: reload to a bit that reads 1, old bit read 0
    tag = "R7";
    tb = 0; cyc();
    tb = 64'h1 << 40;
    write_cfg(1, 3, 5);
    cyc();
    chk("R7 no event after reload", int'(evt_o), 0);
    cyc();
    chk("R7 steady high", int'(evt_o), 0);
    // R1: real rise on bit 40
    tag = "R1";
    tb = 0; cyc();
    tb = 64'h1 << 40; cyc();
    chk("R1 rise event", int'(evt_o), 1);
    cyc();
    chk("R1 single cycle", int'(evt_o), 0);
    // R8: falling bit
    tag = "R8";
    tb = 0; cyc();
    chk("R8 fall no event", int'(evt_o), 0);

    // mixed random traffic
    tag = "R1";
    for (int i = 0; i < 3000; i++) begin
      if (($urandom % 4) == 0) tb = {$urandom, $urandom};
      else tb = tb + 64'(1);
      pend = (($urandom % 4) == 0);
      if (($urandom % 16) == 0) begin
        wr = 1; ext = 1'($urandom); per = 2'($urandom); xt = 4'($urandom);
      end else wr = 0;
      cyc();
    end
    wr = 0;

    // reset again mid-run
    tag = "R4";
    rst_n = 0; cyc(); cyc();
    chk("R4 reset idx", int'(idx_o), 21);
    rst_n = 1; repeat (3) cyc();

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule